// File: doc/BRIEF.md
# Trap Vector and Processor Status Controller

This block keeps the processor status word and decides which pending trap is taken next. The status word holds four one-bit state fields: spare, user mode, traps enabled and reschedule pending. Each is paired with a keep bit that protects it during a software write, so that several fields can be changed together or left alone in a single write. A read returns every keep bit as zero, which makes a read-then-write-back sequence a no-op.

Trap requests come in as 64 level-sensitive lines grouped in four quadrants of sixteen. The controller masks the requests by quadrant rules, picks the lowest-numbered eligible line, and reports it with a one-cycle strobe plus the handler's word address. It then waits for the handler acknowledge before looking at requests again. Leaving reset, it first issues the reset trap (index 7) as a plain transfer.

The controller is a four-state machine:
- BOOT: entered by reset. Always moves to ISSUE, with index 7 preloaded.
- IDLE: if any request is eligible, latches the winning index and moves to ISSUE. Otherwise it stays in IDLE.
- ISSUE: raises the strobe for one cycle, then always moves to HOLD.
- HOLD: keeps the vector steady. It returns to IDLE on acknowledge and stays in HOLD otherwise.

Top module: `trap_vector_ctrl`

## Requirements
- R1: A status write updates each value bit only when its keep bit is 0. The field pairs in the write data are, as keep:value, spare 7:6, user mode 5:4, traps enabled 3:2 and reschedule 1:0. Bits 31:8 of the write data have no effect.
- R2: The status read word is {16 zero bits, VERSION in bits 15:8, the eight field bits}, with every keep bit read as 0. Writing back the read word leaves the state unchanged, and writing all zeros clears all four value bits.
- R3: After reset all four value bits are 0. The first trap strobe is for index 7, one cycle after the first clock edge with reset released.
- R4: The vector equals 0x0004_0400 + 4 × index. It is valid from the strobe cycle until the acknowledge is taken.
- R5: When several eligible requests are pending, the lowest index is taken.
- R6: Indices 8–15 are eligible only while traps are enabled. A masked level request remains pending and is taken once traps are enabled.
- R7: Indices 0–7 and 16–47 are taken whether or not traps are enabled.
- R8: Requests on indices 48–63 are ignored. They cause no strobe and do not change the status.
- R9: Taking any index 0–15 clears traps-enabled at the end of the strobe cycle. Taking an index 16–47 leaves it unchanged.
- R10: The strobe lasts one cycle. No further trap is taken and the vector does not change until the handler acknowledge is seen in the HOLD state.
- R11: If a status write lands in the strobe cycle of an index 0–15 trap, traps-enabled still ends up 0.
- R12: The user_mode and traps_enabled outputs always equal status read bits 4 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts the reset trap on release |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 32 | Status write data with keep bits |
| stat_rdata | output | 32 | Status read word |
| trap_req | input | 64 | Level trap requests, bit n = trap index n |
| handler_ack | input | 1 | Handler has accepted the current trap |
| trap_taken | output | 1 | One-cycle strobe when a trap is issued |
| trap_vector | output | 32 | Handler word address of the current trap |
| user_mode | output | 1 | User-mode level |
| traps_enabled | output | 1 | Maskable traps enabled level |

## Verification
The assertions assume that trap requests are levels held by the requester until its handler clears them. They also assume that the acknowledge is raised only while a taken trap is outstanding. The stimulus follows both rules: it drops each served request while acknowledging it, and it pulses the acknowledge for one cycle only after the strobe has been seen. Writes are issued between edges and last exactly one cycle, with one deliberately placed in a strobe cycle.

// File: rtl/trap_vector_pkg.sv
package trap_vector_pkg;

    typedef enum logic [1:0] {
        ST_BOOT,
        ST_IDLE,
        ST_ISSUE,
        ST_HOLD
    } tv_state_e;

    // value bits of the status word, held as registers
    typedef struct packed {
        logic spare;
        logic user;
        logic traps_en;
        logic resched;
    } tv_status_t;

endpackage

// File: rtl/tv_status_reg.sv
module tv_status_reg
    import trap_vector_pkg::*;
#(
    parameter int         DATA_W  = 32,
    parameter logic [7:0] VERSION = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              clr_traps_en,
    output logic [DATA_W-1:0] rdata,
    output tv_status_t        stat
);

    localparam int PAD_W = DATA_W - 16;

    tv_status_t stat_nx;
    logic       wdata_unused;

    assign wdata_unused = ^wdata[DATA_W-1:8];

    // keep bit sits one position above its value bit
    always_comb begin
        stat_nx = stat;
        if (wr) begin
            stat_nx.spare    = wdata[7] ? stat.spare    : wdata[6];
            stat_nx.user     = wdata[5] ? stat.user     : wdata[4];
            stat_nx.traps_en = wdata[3] ? stat.traps_en : wdata[2];
            stat_nx.resched  = wdata[1] ? stat.resched  : wdata[0];
        end
        if (clr_traps_en) begin
            stat_nx.traps_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat <= '0;
        end else begin
            stat <= stat_nx;
        end
    end

    assign rdata = {{PAD_W{1'b0}}, VERSION,
                    1'b0, stat.spare, 1'b0, stat.user,
                    1'b0, stat.traps_en, 1'b0, stat.resched};

endmodule

// File: rtl/tv_trap_select.sv
module tv_trap_select #(
    parameter int NUM_TRAPS  = 64,
    parameter int QUAD_SIZE  = 16,
    parameter int LIVE_QUADS = 3,
    localparam int IDX_W     = $clog2(NUM_TRAPS)
) (
    input  logic [NUM_TRAPS-1:0] req,
    input  logic                 traps_en,
    output logic                 hit,
    output logic [IDX_W-1:0]     idx
);

    logic [NUM_TRAPS-1:0] elig;

    for (genvar i = 0; i < NUM_TRAPS; i++) begin : g_elig
        localparam int QUAD = i / QUAD_SIZE;
        localparam int POS  = i % QUAD_SIZE;
        if (QUAD == 0 && POS >= QUAD_SIZE / 2) begin : g_mask
            assign elig[i] = req[i] & traps_en;
        end else if (QUAD < LIVE_QUADS) begin : g_live
            assign elig[i] = req[i];
        end else begin : g_dead
            assign elig[i] = req[i] & 1'b0;
        end
    end

    // lowest index wins: scan downward so the last hit kept is the lowest
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int k = NUM_TRAPS - 1; k >= 0; k--) begin
            if (elig[k]) begin
                hit = 1'b1;
                idx = k[IDX_W-1:0];
            end
        end
    end

endmodule

// File: rtl/trap_vector_ctrl.sv
module trap_vector_ctrl
    import trap_vector_pkg::*;
#(
    parameter int          DATA_W      = 32,
    parameter int          ADDR_W      = 32,
    parameter int          NUM_TRAPS   = 64,
    parameter int          QUAD_SIZE   = 16,
    parameter int          LIVE_QUADS  = 3,
    parameter int          RESET_TRAP  = 7,
    parameter int          TRAP_STRIDE = 4,
    parameter int          XOP_SLOTS   = 256,
    parameter logic [31:0] XOP_BASE    = 32'o1000000,
    parameter logic [7:0]  VERSION     = 8'h01
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stat_wr,
    input  logic [DATA_W-1:0]    stat_wdata,
    output logic [DATA_W-1:0]    stat_rdata,
    input  logic [NUM_TRAPS-1:0] trap_req,
    input  logic                 handler_ack,
    output logic                 trap_taken,
    output logic [ADDR_W-1:0]    trap_vector,
    output logic                 user_mode,
    output logic                 traps_enabled
);

    localparam int          IDX_W     = $clog2(NUM_TRAPS);
    localparam int          QSEL_W    = IDX_W - $clog2(QUAD_SIZE);
    localparam logic [ADDR_W-1:0] TRAP_BASE =
        ADDR_W'(XOP_BASE) + ADDR_W'(XOP_SLOTS * TRAP_STRIDE);
    localparam logic [IDX_W-1:0] BOOT_IDX = IDX_W'(RESET_TRAP);

    tv_state_e        state_q, state_nx;
    logic [IDX_W-1:0] idx_q, sel_idx;
    logic             sel_hit, load_idx, clr_te;
    tv_status_t       stat;

    tv_status_reg #(
        .DATA_W  (DATA_W),
        .VERSION (VERSION)
    ) u_status (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (stat_wr),
        .wdata        (stat_wdata),
        .clr_traps_en (clr_te),
        .rdata        (stat_rdata),
        .stat         (stat)
    );

    tv_trap_select #(
        .NUM_TRAPS  (NUM_TRAPS),
        .QUAD_SIZE  (QUAD_SIZE),
        .LIVE_QUADS (LIVE_QUADS)
    ) u_select (
        .req      (trap_req),
        .traps_en (stat.traps_en),
        .hit      (sel_hit),
        .idx      (sel_idx)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        load_idx = 1'b0;
        unique case (state_q)
            ST_BOOT:  state_nx = ST_ISSUE;
            ST_IDLE: begin
                if (sel_hit) begin
                    state_nx = ST_ISSUE;
                    load_idx = 1'b1;
                end
            end
            ST_ISSUE: state_nx = ST_HOLD;
            ST_HOLD: begin
                if (handler_ack) begin
                    state_nx = ST_IDLE;
                end
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_BOOT;
            idx_q   <= BOOT_IDX;
        end else begin
            state_q <= state_nx;
            if (load_idx) begin
                idx_q <= sel_idx;
            end
        end
    end

    // outputs
    always_comb begin
        trap_taken    = (state_q == ST_ISSUE);
        clr_te        = trap_taken && (idx_q[IDX_W-1 -: QSEL_W] == '0);
        trap_vector   = TRAP_BASE + (ADDR_W'(idx_q) * ADDR_W'(TRAP_STRIDE));
        user_mode     = stat.user;
        traps_enabled = stat.traps_en;
    end

endmodule

// File: rtl/trap_vector_checker.sv
module trap_vector_checker
    import trap_vector_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 32,
    parameter int QUAD_SIZE = 16,
    parameter int LIVE      = 48,
    parameter int STRIDE    = 4,
    parameter logic [ADDR_W-1:0] BASE = 32'h0004_0400
) (
    input logic              clk,
    input logic              rst_n,
    input logic              trap_taken,
    input logic [ADDR_W-1:0] trap_vector,
    input logic [DATA_W-1:0] stat_rdata,
    input logic              user_mode,
    input logic              traps_enabled,
    input tv_state_e         state
);

    localparam logic [ADDR_W-1:0] Q0_END   = BASE + ADDR_W'(QUAD_SIZE * STRIDE);
    localparam logic [ADDR_W-1:0] MASK_LO  = BASE + ADDR_W'((QUAD_SIZE / 2) * STRIDE);
    localparam logic [ADDR_W-1:0] LIVE_END = BASE + ADDR_W'(LIVE * STRIDE);

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |=> !trap_taken);

    assert_vector_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> $stable(trap_vector));

    assert_vector_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (trap_vector >= BASE && trap_vector < LIVE_END
                        && trap_vector[1:0] == 2'b00));

    assert_q0_disables_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && trap_vector < Q0_END) |=> !traps_enabled);

    assert_masked_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_taken && trap_vector >= MASK_LO && trap_vector < Q0_END)
            |-> $past(traps_enabled));

    assert_keep_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rdata[7] | stat_rdata[5] | stat_rdata[3] | stat_rdata[1]) == 1'b0);

    assert_levels_match_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (user_mode == stat_rdata[4]) && (traps_enabled == stat_rdata[2]));

endmodule

bind trap_vector_ctrl trap_vector_checker #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .QUAD_SIZE (QUAD_SIZE),
    .LIVE      (LIVE_QUADS * QUAD_SIZE),
    .STRIDE    (TRAP_STRIDE),
    .BASE      (TRAP_BASE)
) u_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .trap_taken    (trap_taken),
    .trap_vector   (trap_vector),
    .stat_rdata    (stat_rdata),
    .user_mode     (user_mode),
    .traps_enabled (traps_enabled),
    .state         (state_q)
);

// File: tb/trap_vector_ctrl_bench.sv
module trap_vector_ctrl_bench;

    localparam logic [7:0]  VER  = 8'h2A;
    localparam logic [31:0] BASE = 32'h0004_0400;
    localparam logic [31:0] VHI  = {16'h0, VER, 8'h00};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stat_wr = 1'b0;
    logic [31:0] stat_wdata = '0;
    logic [31:0] stat_rdata;
    logic [63:0] trap_req = '0;
    logic        handler_ack = 1'b0;
    logic        trap_taken;
    logic [31:0] trap_vector;
    logic        user_mode, traps_enabled;

    int checks = 0;
    int bad = 0;
    int taken_cnt = 0;
    bit done = 0;
    logic [31:0] exp_q[$];

    always #4 clk = ~clk;

    trap_vector_ctrl #(.VERSION(VER)) u_trap_vector_ctrl (
        .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .stat_rdata(stat_rdata), .trap_req(trap_req), .handler_ack(handler_ack),
        .trap_taken(trap_taken), .trap_vector(trap_vector),
        .user_mode(user_mode), .traps_enabled(traps_enabled)
    );

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && trap_taken) begin
            taken_cnt++;
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected trap", trap_vector, 32'h0);
            end else begin
                automatic logic [31:0] e = exp_q.pop_front();
                check(trap_vector == e, "R4 R5 vector", trap_vector, e);
            end
        end
    end

    task automatic expect_trap(int idx);
        exp_q.push_back(BASE + 32'(idx) * 4);
    endtask

    task automatic wait_taken(int start);
        for (int n = 0; n < 20; n++) begin
            if (taken_cnt > start) return;
            @(posedge clk); #2;
        end
        check(taken_cnt > start, "R6 R7 trap not taken", 32'(taken_cnt), 32'(start + 1));
    endtask

    task automatic finish_trap(logic [63:0] drop);
        trap_req    = trap_req & ~drop;
        handler_ack = 1'b1;
        @(posedge clk); #2;
        handler_ack = 1'b0;
    endtask

    task automatic wr(logic [31:0] d);
        stat_wr = 1'b1; stat_wdata = d;
        @(posedge clk); #2;
        stat_wr = 1'b0;
    endtask

    task automatic take(int idx, logic [63:0] reqs);
        int s = taken_cnt;
        expect_trap(idx);
        trap_req = trap_req | reqs;
        wait_taken(s);
    endtask

    task automatic quiet(int n, string req);
        int s = taken_cnt;
        repeat (n) begin @(posedge clk); #2; end
        check(taken_cnt == s, req, 32'(taken_cnt), 32'(s));
    endtask

    initial begin
        #(8 * 50000);
        check(0, "watchdog expired", 32'h0, 32'h1);
        summary();
    end

    initial begin
        int s;
        repeat (3) @(posedge clk); #2;
        check(stat_rdata == VHI, "R3 reset status", stat_rdata, VHI);
        check({user_mode, traps_enabled} == 2'b00, "R3 reset levels",
              32'({user_mode, traps_enabled}), 32'h0);
        expect_trap(7);                       // R3 boot trap
        rst_n = 1'b1;
        @(posedge clk); #2;
        wait_taken(0);
        finish_trap('0);

        wr(32'h0000_0055);
        check(stat_rdata == (VHI | 32'h55), "R1 set all values", stat_rdata, VHI | 32'h55);
        check({user_mode, traps_enabled} == 2'b11, "R12 levels follow status",
              32'({user_mode, traps_enabled}), 32'h3);
        wr(32'h0000_00AA);
        check(stat_rdata == (VHI | 32'h55), "R1 keep all", stat_rdata, VHI | 32'h55);
        wr(32'hFFFF_FFA8);
        check(stat_rdata == (VHI | 32'h54), "R1 clear reschedule only", stat_rdata, VHI | 32'h54);
        wr(stat_rdata);
        check(stat_rdata == (VHI | 32'h54), "R2 write-back no-op", stat_rdata, VHI | 32'h54);
        wr(32'h0);
        check(stat_rdata == VHI, "R2 zero clears", stat_rdata, VHI);

        // R5 R6 R9: 9 beats 20 while enabled; quadrant 0 then disables
        wr(32'h4);
        take(9, (64'h1 << 9) | (64'h1 << 20));
        check(traps_enabled == 1'b0, "R9 quadrant 0 disables", 32'(traps_enabled), 32'h0);
        finish_trap(64'h1 << 9);
        s = taken_cnt; expect_trap(20); wait_taken(s);   // R7
        finish_trap(64'h1 << 20);

        wr(32'h4);
        take(33, 64'h1 << 33);
        check(traps_enabled == 1'b1, "R9 quadrant 2 keeps enable", 32'(traps_enabled), 32'h1);
        finish_trap(64'h1 << 33);

        // R6 masked request stays pending
        wr(32'h0);
        trap_req = 64'h1 << 12;
        quiet(6, "R6 masked while disabled");
        expect_trap(12);
        s = taken_cnt;
        wr(32'h4);
        wait_taken(s);
        finish_trap(64'h1 << 12);

        // R7 unmaskable while disabled
        take(3, 64'h1 << 3);
        finish_trap(64'h1 << 3);
        take(40, 64'h1 << 40);
        finish_trap(64'h1 << 40);

        // R8 reserved quadrant
        wr(32'h4);
        trap_req = 64'h1 << 50;
        quiet(6, "R8 reserved ignored");
        check(stat_rdata == (VHI | 32'h4), "R8 status untouched", stat_rdata, VHI | 32'h4);
        take(0, 64'h1 | (64'h1 << 63));       // R5 R4 lowest index
        finish_trap('1);

        take(47, 64'h1 << 47);                // R4 last live vector
        finish_trap('1);

        // R10 no progress without acknowledge
        take(21, (64'h1 << 21) | (64'h1 << 22));
        quiet(4, "R10 waits for ack");
        check(trap_vector == BASE + 32'd84, "R10 vector held", trap_vector, BASE + 32'd84);
        finish_trap('1);
        quiet(3, "R10 no trap after release");

        // R11 write during a quadrant 0 strobe
        wr(32'h4);
        s = taken_cnt;
        expect_trap(1);
        trap_req = 64'h2;
        @(posedge clk); #2;
        stat_wr = 1'b1; stat_wdata = 32'h4;
        @(posedge clk); #2;
        stat_wr = 1'b0;
        check(taken_cnt == s + 1, "R11 strobe seen", 32'(taken_cnt), 32'(s + 1));
        check(traps_enabled == 1'b0, "R11 clear beats write", 32'(traps_enabled), 32'h0);
        finish_trap('1);

        quiet(3, "R10 idle at end");
        check(exp_q.size() == 0, "R5 scoreboard drained", 32'(exp_q.size()), 32'h0);
        summary();
    end

endmodule